// File: doc/BRIEF.md
# Alarm indication window monitor

This block watches the NRZ bit stream produced by a line decoder and raises an alarm when the stream looks like the all-ones maintenance pattern. It does not track runs of ones. It counts the zeros that arrive during a measurement window. Surrounding logic defines that window by holding an active-low window input high. When that input drops, the block compares the number of zeros seen in the window with a threshold and stores the result in a registered alarm flag. It then clears its counter for the next window.

The decision is taken once, on the first decoder clock that samples the window input low. While the input stays low the counter is held at zero and the flag keeps its value. A zero counts only when the data-valid strobe is high, so the decoder can stall the stream without disturbing the count. The counter saturates at the threshold, which keeps it as small as the comparison allows.

Top module: `aisw_monitor`

## Requirements
- R1: After a synchronous reset (`rst` high on a rising edge of `clk`), `ais_o` is 0.
- R2: While `win_n` is 1, each clock in which `bit_vld` is 1 and `bit_in` is 0 adds one decoded zero to the window count.
- R3: A clock in which `bit_in` is 1, or in which `bit_vld` is 0, adds nothing to the window count.
- R4: On the first clock that samples `win_n` at 0 after a clock that sampled it at 1, `ais_o` becomes 1 if fewer than ZERO_LIMIT (default 3) zeros were counted in the window, and 0 otherwise. The new value is visible after that edge.
- R5: Any clock that samples `win_n` at 0 clears the window count, and zeros presented while `win_n` is 0 are not counted.
- R6: `ais_o` changes only at the decision edge of R4. It holds while `win_n` stays 0 and throughout a window.
- R7: The count saturates at ZERO_LIMIT, so any number of zeros at or above the limit, however large, yields `ais_o` = 0.
- R8: If `win_n` is 0 on the first clocks after reset and no clock with `win_n` at 1 has preceded it, no decision is made and `ais_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Decoded NRZ bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| win_n | input | 1 | Window control: 1 = counting, 0 = decide and clear |
| ais_o | output | 1 | Registered alarm flag, 1 = too few zeros in the last window |

## Verification
Windows are swept over every zero count from zero to nine. Each count is tried in three arrangements: zeros back to back, zeros separated by ones, and zeros interleaved with strobe-low zero bits. Together these separate an off-by-one threshold from a counter that counts unqualified bits. Counts above the limit expose a counter that wraps instead of saturating. Longer low pulses that carry zero bits show whether the flag holds and the counter ignores data while cleared. A low input straight after reset checks that no decision is taken without a preceding window.

// File: rtl/aisw_pkg.sv
`timescale 1ns/1ps
package aisw_pkg;
  // Width needed to hold values 0..lim.
  function automatic int cnt_bits(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/aisw_zero_cnt.sv
`timescale 1ns/1ps
// Saturating counter of qualified zero bits.
module aisw_zero_cnt #(
  parameter int LIMIT = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] SAT = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != SAT)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aisw_verdict.sv
`timescale 1ns/1ps
// Detects the start of a low window pulse and registers the alarm decision.
module aisw_verdict #(
  parameter int LIMIT = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_n,
  input  logic [CW-1:0] cnt,
  output logic          ais
);
  localparam logic [CW-1:0] THR = CW'(LIMIT);

  logic win_q;
  logic fire;

  // A window must have been open (sampled high) before a decision counts.
  assign fire = !win_n && win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      ais   <= 1'b0;
    end else begin
      win_q <= win_n;
      if (fire) begin
        ais <= (cnt < THR);
      end
    end
  end
endmodule

// File: rtl/aisw_monitor.sv
`timescale 1ns/1ps
module aisw_monitor #(
  parameter int ZERO_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic win_n,
  output logic ais_o
);
  localparam int CW = aisw_pkg::cnt_bits(ZERO_LIMIT);

  logic [CW-1:0] zcnt;
  logic          zero_hit;

  assign zero_hit = win_n && bit_vld && !bit_in;

  aisw_zero_cnt #(.LIMIT(ZERO_LIMIT), .CW(CW)) cnt_i (
    .clk (clk),
    .rst (rst),
    .clr (!win_n),
    .inc (zero_hit),
    .cnt (zcnt)
  );

  aisw_verdict #(.LIMIT(ZERO_LIMIT), .CW(CW)) dec_i (
    .clk   (clk),
    .rst   (rst),
    .win_n (win_n),
    .cnt   (zcnt),
    .ais   (ais_o)
  );
endmodule

// File: rtl/aisw_monitor_chk.sv
`timescale 1ns/1ps
module aisw_monitor_chk #(
  parameter int LIMIT = 3,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_in,
  input logic          bit_vld,
  input logic          win_n,
  input logic          ais,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] THR = CW'(LIMIT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= THR); // R7

  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
    (win_n && bit_vld && !bit_in && cnt < THR) |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_NO_COUNT_OTHER: assert property (@(posedge clk) disable iff (rst)
    (win_n && (bit_in || !bit_vld)) |=> $stable(cnt)); // R3

  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
    !win_n |=> (cnt == '0)); // R5

  AST_DECIDE: assert property (@(posedge clk) disable iff (rst)
    (!win_n && $past(win_n)) |=> (ais == ($past(cnt) < THR))); // R4

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!win_n && !$past(win_n)) |=> $stable(ais)); // R6

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (rst)
    win_n |=> $stable(ais)); // R6
endmodule

bind aisw_monitor aisw_monitor_chk #(.LIMIT(ZERO_LIMIT), .CW(CW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .bit_in  (bit_in),
  .bit_vld (bit_vld),
  .win_n   (win_n),
  .ais     (ais_o),
  .cnt     (zcnt)
);

// File: tb/aisw_monitor_tb_top.sv
`timescale 1ns/1ps
module aisw_monitor_tb_top;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b1;
  logic bit_vld = 1'b0;
  logic win_n = 1'b0;
  logic ais_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aisw_monitor #(.ZERO_LIMIT(LIM)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .win_n   (win_n),
    .ais_o   (ais_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: ais_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic w, input logic v, input logic b);
    @(negedge clk);
    win_n = w; bit_vld = v; bit_in = b;
  endtask

  // One window with nz zeros in a given arrangement, then a low pulse.
  task automatic window(input int nz, input int arr, input int low_len, input string req);
    drive(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < nz; i++) begin
      if (arr == 1) drive(1'b1, 1'b1, 1'b1);           // R3: ones between zeros
      if (arr == 2) drive(1'b1, 1'b0, 1'b0);           // R3: unqualified zero
      drive(1'b1, 1'b1, 1'b0);
    end
    if (arr == 2) begin
      drive(1'b1, 1'b0, 1'b0);
      drive(1'b1, 1'b0, 1'b0);
    end
    drive(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < low_len; k++) begin
      drive(1'b0, 1'b1, 1'b0);                          // R5: zeros while low ignored
      @(negedge clk);
      check(ais_o, (nz < LIM), req);                    // R4 decision, R6 hold
      win_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b0;
    end
  endtask

  initial begin
    // R8: low window input right from reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ais_o, 1'b0, "R1");
    repeat (3) begin
      @(negedge clk);
      check(ais_o, 1'b0, "R8");
    end

    for (int nz = 0; nz < 10; nz++) begin
      for (int arr = 0; arr < 3; arr++) begin
        window(nz, arr, 1 + arr, nz >= LIM ? "R7" : "R2");
      end
    end

    // R5: long low pulse full of zeros, then a two-zero window must still alarm
    window(5, 0, 6, "R5");
    window(2, 0, 1, "R5");
    // R6: flag holds during an open window with zeros arriving
    drive(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check(ais_o, 1'b1, "R6");
    // R4: exactly at the threshold clears the alarm
    window(3, 1, 1, "R4");
    window(LIM - 1, 2, 1, "R4");

    // R1: reset mid-stream returns flag to 0
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ais_o, 1'b0, "R1");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule